// File: doc/BRIEF.md
# Two-Color Serial Symbol Decoder

This block rebuilds bytes from a pair of indicator lines, one red and one green, that are sampled once per symbol slot. Each time the sample strobe is high the decoder reads one slot: a slot in which exactly one line is lit carries a bit, and a slot with both lines dark closes a character. A character is eight data bits, least significant first, then a parity slot that holds the XOR of the data bits, then the dark closing slot.

Upstream logic turns camera frames or photodiode levels into the two line levels and lines up the strobe so that there is one strobe per slot, for example one per 30 Hz frame. The decoder reports each finished character as a one-clock valid pulse with the byte and a parity status. A malformed slot sequence gives a one-clock framing-error pulse, and the decoder then waits for the next character.

Top module: `twocolor_decoder`

## Requirements
- R1: Slot encoding as {red_i, green_i}: 2'b01 (green lit, red dark) is data bit 0, and 2'b10 (red lit, green dark) is data bit 1.
- R2: The first eight lit slots of a character are the data bits, least significant bit first. byte_o shows them with bit 0 taken from the first slot.
- R3: The ninth lit slot is the parity bit. parity_err_o is high together with valid_o exactly when that bit differs from the XOR of the eight data bits. parity_err_o is never high without valid_o.
- R4: A dark slot (2'b00) that follows the ninth lit slot makes valid_o high for exactly one clock, in the cycle after the clock edge that samples it, with byte_o updated in that same cycle.
- R5: While idle, dark slots produce no output, and the first slot with exactly one line lit starts a new character.
- R6: A slot with both lines lit (2'b11), whether idle or inside a character, raises frame_err_o for one clock and leaves the decoder idle.
- R7: A dark slot before nine bits have been collected raises frame_err_o for one clock and returns the decoder to idle.
- R8: A lit slot where the closing dark slot is expected raises frame_err_o for one clock and returns the decoder to idle. That slot does not start a new character.
- R9: In a clock with sample_i low, the line levels are ignored: no output pulse follows, and the decoder state is unchanged.
- R10: Reset (rst_ni low) clears the bit counter, the shift register, valid_o, byte_o, parity_err_o and frame_err_o. Decoding starts cleanly afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Slot strobe; one slot is consumed per high cycle |
| red_i | input | 1 | Red line level, 1 = lit |
| green_i | input | 1 | Green line level, 1 = lit |
| valid_o | output | 1 | One-clock pulse when a character has been received |
| byte_o | output | 8 | Recovered data byte, held until the next character |
| parity_err_o | output | 1 | Parity mismatch, qualified by valid_o |
| frame_err_o | output | 1 | One-clock pulse for a malformed slot sequence |

## Verification
The assertions check the following on every cycle:
- A clock without a strobe changes neither the state, the bit count nor the shift register, and it is followed by no output pulse.
- The bit count never passes the character length.
- valid_o never stays high for two cycles.
- valid_o and frame_err_o are never high together.
- parity_err_o appears only together with valid_o.

Only the bench scenarios can show that the decoder gets the bit order, the byte value and the parity verdict right, and that it rejects each malformed sequence in the right slot. The malformed sequences are both lines lit while idle and inside a character, a dark slot that cuts a character short, and a lit slot where the closing slot belongs. The same holds for recovery into a clean character after each error and after a reset in the middle of a character.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  // encoding is {red, green}
  typedef enum logic [1:0] {
    SLOT_DARK = 2'b00,
    SLOT_ZERO = 2'b01,
    SLOT_ONE  = 2'b10,
    SLOT_BOTH = 2'b11
  } slot_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_STOP = 2'd2
  } state_e;
endpackage

// File: rtl/tcd_slot_classify.sv
module tcd_slot_classify
  import tcd_pkg::*;
(
  input  logic  red_i,
  input  logic  green_i,
  output slot_e slot_o,
  output logic  bit_o
);
  always_comb begin
    unique case ({red_i, green_i})
      2'b00:   slot_o = SLOT_DARK;
      2'b01:   slot_o = SLOT_ZERO;
      2'b10:   slot_o = SLOT_ONE;
      default: slot_o = SLOT_BOTH;
    endcase
  end

  assign bit_o = red_i;
endmodule

// File: rtl/tcd_frame_fsm.sv
module tcd_frame_fsm
  import tcd_pkg::*;
#(
  parameter int FRAME_W = 9
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sample_i,
  input  slot_e slot_i,
  output logic  shift_o,
  output logic  done_o,
  output logic  ferr_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lit;

  assign lit = (slot_i == SLOT_ZERO) || (slot_i == SLOT_ONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_o = 1'b0;
    done_o  = 1'b0;
    ferr_o  = 1'b0;
    if (sample_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (lit) begin
            shift_o = 1'b1;
            cnt_d   = CNT_W'(1);
            state_d = ST_DATA;
          end else if (slot_i == SLOT_BOTH) begin
            ferr_o = 1'b1;
          end
        end
        ST_DATA: begin
          if (lit) begin
            shift_o = 1'b1;
            if (cnt_q == LAST) begin
              cnt_d   = '0;
              state_d = ST_STOP;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end else begin
            ferr_o  = 1'b1;
            cnt_d   = '0;
            state_d = ST_IDLE;
          end
        end
        default: begin
          if (slot_i == SLOT_DARK) done_o = 1'b1;
          else                     ferr_o = 1'b1;
          cnt_d   = '0;
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(FRAME_W));

  p_hold_state_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(state_q) && $stable(cnt_q));

  p_stop_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> (cnt_q == '0));
endmodule

// File: rtl/tcd_shifter.sv
module tcd_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o
);
  localparam int FRAME_W = DATA_W + 1;

  logic [FRAME_W-1:0] sr_q;

  // LSB first: new bits enter at the top and move down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {bit_i, sr_q[FRAME_W-1:1]};
  end

  assign data_o = sr_q[DATA_W-1:0];
  assign perr_o = sr_q[FRAME_W-1] ^ (^sr_q[DATA_W-1:0]);

  p_sr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q));
endmodule

// File: rtl/twocolor_decoder.sv
module twocolor_decoder
  import tcd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              red_i,
  input  logic              green_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              parity_err_o,
  output logic              frame_err_o
);
  localparam int FRAME_W = DATA_W + 1;

  slot_e             slot;
  logic              slot_bit;
  logic              shift, done, ferr, perr;
  logic [DATA_W-1:0] data;

  tcd_slot_classify u_cls (
    .red_i   (red_i),
    .green_i (green_i),
    .slot_o  (slot),
    .bit_o   (slot_bit)
  );

  tcd_frame_fsm #(.FRAME_W(FRAME_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .slot_i   (slot),
    .shift_o  (shift),
    .done_o   (done),
    .ferr_o   (ferr)
  );

  tcd_shifter #(.DATA_W(DATA_W)) u_sr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .bit_i   (slot_bit),
    .data_o  (data),
    .perr_o  (perr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      byte_o       <= '0;
      parity_err_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      valid_o      <= done;
      parity_err_o <= done & perr;
      frame_err_o  <= ferr;
      if (done) byte_o <= data;
    end
  end

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> !valid_o && !frame_err_o);

  p_perr_qual_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> valid_o);

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && frame_err_o));

  p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: tb/sim_twocolor_decoder.sv
module sim_twocolor_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sample_i = 1'b0;
  logic       red_i = 1'b0;
  logic       green_i = 1'b0;
  logic       valid_o, parity_err_o, frame_err_o;
  logic [7:0] byte_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    bit         is_valid;
    logic [7:0] b;
    bit         perr;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  twocolor_decoder u0 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sample_i     (sample_i),
    .red_i        (red_i),
    .green_i      (green_i),
    .valid_o      (valid_o),
    .byte_o       (byte_o),
    .parity_err_o (parity_err_o),
    .frame_err_o  (frame_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // one slot per strobe; the gap cycle carries both-lit garbage that must be ignored (R9)
  task automatic slot(input logic r, input logic g);
    @(negedge clk_i);
    red_i = r; green_i = g; sample_i = 1'b1;
    @(negedge clk_i);
    sample_i = 1'b0; red_i = 1'b1; green_i = 1'b1;
  endtask

  task automatic push_valid(input logic [7:0] b, input bit perr, input string tag);
    exp_t e;
    e.is_valid = 1; e.b = b; e.perr = perr; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_ferr(input string tag);
    exp_t e;
    e.is_valid = 0; e.b = '0; e.perr = 0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) slot(b[i], ~b[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit flip, input string tag);
    logic p;
    p = (^b) ^ flip;
    send_bits(b, 8);
    slot(p, ~p);
    push_valid(b, flip, tag);
    slot(1'b0, 1'b0);
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R4", "valid width", valid_o, 0);
  endtask

  // monitor: every output pulse must match the next queued item
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      if (rst_ni && (valid_o || frame_err_o)) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected pulse", {valid_o, frame_err_o}, 0);
        end else begin
          e = exp_q.pop_front();
          if (e.is_valid) begin
            chk(valid_o && !frame_err_o, e.tag, "valid", valid_o, 1);
            chk(byte_o == e.b, e.tag, "byte", byte_o, e.b);
            chk(parity_err_o == e.perr, e.tag, "parity_err", parity_err_o, e.perr);
          end else begin
            chk(frame_err_o && !valid_o, e.tag, "frame_err", frame_err_o, 1);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({valid_o, parity_err_o, frame_err_o} == 3'b000, "R10", "flags in reset",
        {valid_o, parity_err_o, frame_err_o}, 0);
    chk(byte_o == 8'h00, "R10", "byte in reset", byte_o, 0);
    rst_ni = 1'b1;

    // R5: dark slots while idle are ignored
    for (int i = 0; i < 4; i++) slot(1'b0, 1'b0);
    send_byte(8'h48, 0, "R5");
    // R1 R2 R4 under several patterns
    send_byte(8'h00, 0, "R1");
    send_byte(8'hFF, 0, "R1");
    send_byte(8'h01, 0, "R2");
    send_byte(8'h80, 0, "R2");
    send_byte(8'hA5, 0, "R4");
    // R3: wrong parity bit
    send_byte(8'h3C, 1, "R3");
    send_byte(8'h01, 1, "R3");

    // R6: both lit while idle, then inside a character
    push_ferr("R6");
    slot(1'b1, 1'b1);
    send_bits(8'h55, 3);
    push_ferr("R6");
    slot(1'b1, 1'b1);
    send_byte(8'h96, 0, "R6");

    // R7: dark after five bits
    send_bits(8'hC3, 5);
    push_ferr("R7");
    slot(1'b0, 1'b0);
    send_byte(8'h21, 0, "R7");

    // R8: lit slot where the end slot belongs, then idle dark slot is ignored
    send_bits(8'h7E, 8);
    slot(^8'h7E, ~(^8'h7E));
    push_ferr("R8");
    slot(1'b1, 1'b0);
    slot(1'b0, 1'b0);
    send_byte(8'h5A, 0, "R8");

    // R9: a long stretch with no strobe and busy lines
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      red_i = i[0]; green_i = i[1];
    end
    send_byte(8'hE7, 0, "R9");

    // R10: reset clears held byte and a half-built character
    send_byte(8'h7E, 0, "R10");
    send_bits(8'hFF, 4);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(byte_o == 8'h00, "R10", "byte after reset", byte_o, 0);
    chk({valid_o, parity_err_o, frame_err_o} == 3'b000, "R10", "flags after reset",
        {valid_o, parity_err_o, frame_err_o}, 0);
    rst_ni = 1'b1;
    send_byte(8'h0F, 0, "R10");

    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R4", "missing pulses", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule